// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits in front of the CPU and PCI clock output pads of a motherboard clock generator. It turns groups of clock outputs on and off in response to two asynchronous, active-low stop requests. It does this without ever emitting a shortened pulse, and it holds every stopped output at a solid LOW. A board strap is captured during reset and selects one of two modes. In mobile mode the two shared pads are stop-request inputs. In desktop mode the same pads are memory clock outputs, the stop requests are ignored and the CPU and PCI clocks run freely.

The CPU stop request is first sampled on the free-running PCI clock. It then crosses into the CPU clock domain through a synchronizer chain. The PCI stop request is sampled directly on the PCI clock. In each domain a gate-enable register updates on the falling clock edge. Each output is the input clock ANDed with its enable, so an output can only start or stop at a whole-cycle boundary. A per-output enable bit is combined into the same register. A global three-state input floats all clock outputs. The free-running PCI clock is passed straight through, and no stop request ever touches it.

Top module: `clkstop_ctrl`

## Requirements
- R1: The mode is taken from `mode_strap` while `rst` is high, sampled on the free-running PCI clock: strap 1 selects desktop mode and strap 0 selects mobile mode. `mobile_o` is 1 in mobile mode, and this tells the pads that the shared pins are inputs. Changes on `mode_strap` after reset has been released have no effect.
- R2: In desktop mode, `cpu_stop_n` and `pci_stop_n` have no effect. Every CPU and PCI output whose enable bit is 1 runs.
- R3: In mobile mode, `cpu_stop_n` is sampled on rising edges of `clk_pcif`. On a falling request, the CPU outputs produce 2 to 4 more full pulses after the sampling edge and then stay LOW. On a rising request, the CPU outputs skip 2 to 4 CPU clock rising edges after the sampling edge before their first pulse.
- R4: In mobile mode, `pci_stop_n` is sampled on rising edges of `clk_pci`. The PCI output pulse that starts at the sampling edge itself is left as it was. The change in run or stop appears from the next PCI clock cycle onward.
- R5: The CPU stop request never affects the PCI outputs, and the PCI stop request never affects the CPU outputs. `pcif_clk_o` follows `clk_pcif` whatever the stop requests or the reset.
- R6: A stopped output is driven LOW and shows no rising edge.
- R7: No gated output ever produces a high pulse shorter than half a period of its source clock.
- R8: A gated output whose bit in `cpu_en` or `pci_en` is 0 stays LOW. The other outputs in its group keep running.
- R9: While `out_hiz` is 1, all CPU, PCI and free-running PCI clock outputs are high impedance.
- R10: While `rst` is 1, every gated output is LOW. After release with no stop pending, every enabled output runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | CPU clock from the synthesizer |
| clk_pci | input | 1 | PCI clock from the synthesizer |
| clk_pcif | input | 1 | Free-running PCI clock; mode strap and CPU request are sampled here |
| rst | input | 1 | Synchronous active-high reset, seen by every domain |
| mode_strap | input | 1 | Board strap, 1 = desktop, 0 = mobile, captured during reset |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU clock stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI clock stop request |
| cpu_en | input | NUM_CPU | Per-output CPU clock enable, 1 = allowed to run |
| pci_en | input | NUM_PCI | Per-output PCI clock enable, 1 = allowed to run |
| out_hiz | input | 1 | 1 floats all clock outputs |
| mobile_o | output | 1 | 1 when mobile mode was latched (shared pads are inputs) |
| cpu_clk_o | output | NUM_CPU | Gated CPU clock outputs |
| pci_clk_o | output | NUM_PCI | Gated PCI clock outputs |
| pcif_clk_o | output | 1 | Free-running PCI clock output |

## Verification
A corrupted gate-enable register shows up at the very next rising edge of its source clock: the output either misses a pulse or carries one it should not. A stuck or skipped synchronizer stage in the CPU path shows up as a stop or start latency outside the 2 to 4 edge window, and this appears within one PCI cycle of the request changing. A wrongly captured mode register shows at `mobile_o` two PCI cycles after reset release. It also shows as stop requests being obeyed in desktop mode or ignored in mobile mode. Any enable change made during the high phase of a clock shows up as a pulse narrower than half a period.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock stop controller.
package clkstop_pkg;

  // Board mode captured from the strap during reset.
  typedef enum logic {
    BOARD_DESKTOP = 1'b0,
    BOARD_MOBILE  = 1'b1
  } board_mode_e;

  // Level of an active-low stop request when no stop is wanted.
  localparam logic REQ_IDLE = 1'b1;

endpackage

// File: rtl/cs_mode_latch.sv
`timescale 1ns/1ps
// Captures the board strap while reset is held, then freezes it.
module cs_mode_latch
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strap,
  output board_mode_e mode_o
);

  board_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= strap ? BOARD_DESKTOP : BOARD_MOBILE;
    end
  end

  assign mode_o = mode_q;

  // R1: once out of reset for a full cycle, the mode never moves
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

endmodule

// File: rtl/cs_req_sync.sv
`timescale 1ns/1ps
// Chain of flops that samples an asynchronous request into clk's domain.
module cs_req_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];

endmodule

// File: rtl/cs_gate_bank.sv
`timescale 1ns/1ps
// Group of glitch-free clock gates sharing one source clock.
// Enables load on the falling edge, so they only move while clk is low.
module cs_gate_bank #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [WIDTH-1:0] reg_en,
  output logic [WIDTH-1:0] gate_en_o,
  output logic [WIDTH-1:0] gclk_o
);

  localparam logic [WIDTH-1:0] ALL_OFF = '0;

  logic [WIDTH-1:0] en_q;

  always_ff @(negedge clk) begin
    if (rst)      en_q <= ALL_OFF;
    else if (run) en_q <= reg_en;
    else          en_q <= ALL_OFF;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
      assign gclk_o[i] = clk & en_q[i];
    end
  endgenerate

  assign gate_en_o = en_q;

  // R6: a withdrawn run permission clears every enable at that falling edge
  a_r6_stop_clears_enable: assert property (@(negedge clk) disable iff (rst)
    !run |=> (en_q == ALL_OFF));

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
// Top of the synchronized clock stop controller.
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU         = 2,
  parameter int NUM_PCI         = 5,
  parameter int CPU_SYNC_STAGES = 2
) (
  input  logic               clk_cpu,
  input  logic               clk_pci,
  input  logic               clk_pcif,
  input  logic               rst,
  input  logic               mode_strap,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic [NUM_CPU-1:0] cpu_en,
  input  logic [NUM_PCI-1:0] pci_en,
  input  logic               out_hiz,
  output logic               mobile_o,
  output logic [NUM_CPU-1:0] cpu_clk_o,
  output logic [NUM_PCI-1:0] pci_clk_o,
  output logic               pcif_clk_o
);

  localparam logic [NUM_CPU-1:0] CPU_OFF = '0;
  localparam logic [NUM_PCI-1:0] PCI_OFF = '0;

  board_mode_e        mode;
  logic               cpu_req_pcif;
  logic               cpu_req_cpu;
  logic               pci_req_pci;
  logic               cpu_run;
  logic               pci_run;
  logic [NUM_CPU-1:0] cpu_gate_en;
  logic [NUM_CPU-1:0] cpu_gclk;
  logic [NUM_PCI-1:0] pci_gate_en;
  logic [NUM_PCI-1:0] pci_gclk;

  cs_mode_latch u_mode (
    .clk    (clk_pcif),
    .rst    (rst),
    .strap  (mode_strap),
    .mode_o (mode)
  );

  // CPU request: one sample on the free-running PCI clock, then a CDC chain.
  cs_req_sync #(.STAGES(1), .RESET_VAL(REQ_IDLE)) u_cpu_sample (
    .clk  (clk_pcif),
    .rst  (rst),
    .din  (cpu_stop_n),
    .dout (cpu_req_pcif)
  );

  cs_req_sync #(.STAGES(CPU_SYNC_STAGES), .RESET_VAL(REQ_IDLE)) u_cpu_cdc (
    .clk  (clk_cpu),
    .rst  (rst),
    .din  (cpu_req_pcif),
    .dout (cpu_req_cpu)
  );

  // PCI request: a single sample on the PCI clock.
  cs_req_sync #(.STAGES(1), .RESET_VAL(REQ_IDLE)) u_pci_sample (
    .clk  (clk_pci),
    .rst  (rst),
    .din  (pci_stop_n),
    .dout (pci_req_pci)
  );

  assign cpu_run = (mode == BOARD_DESKTOP) || cpu_req_cpu;
  assign pci_run = (mode == BOARD_DESKTOP) || pci_req_pci;

  cs_gate_bank #(.WIDTH(NUM_CPU)) u_cpu_gates (
    .clk       (clk_cpu),
    .rst       (rst),
    .run       (cpu_run),
    .reg_en    (cpu_en),
    .gate_en_o (cpu_gate_en),
    .gclk_o    (cpu_gclk)
  );

  cs_gate_bank #(.WIDTH(NUM_PCI)) u_pci_gates (
    .clk       (clk_pci),
    .rst       (rst),
    .run       (pci_run),
    .reg_en    (pci_en),
    .gate_en_o (pci_gate_en),
    .gclk_o    (pci_gclk)
  );

  assign mobile_o   = (mode == BOARD_MOBILE);
  assign cpu_clk_o  = out_hiz ? {NUM_CPU{1'bz}} : cpu_gclk;
  assign pci_clk_o  = out_hiz ? {NUM_PCI{1'bz}} : pci_gclk;
  assign pcif_clk_o = out_hiz ? 1'bz : clk_pcif;

  // R3: a synchronized CPU stop in mobile mode leaves no CPU gate open
  a_r3_cpu_stop_closes: assert property (@(posedge clk_cpu) disable iff (rst)
    (mode == BOARD_MOBILE && !cpu_req_cpu) |-> (cpu_gate_en == CPU_OFF));

  // R4: a sampled PCI stop in mobile mode has closed the PCI gates by the next edge
  a_r4_pci_stop_closes: assert property (@(posedge clk_pci) disable iff (rst)
    (mode == BOARD_MOBILE && !pci_req_pci) |-> (pci_gate_en == PCI_OFF));

  // R2: in desktop mode the CPU gates follow the register enables alone
  a_r2_desktop_cpu_free: assert property (@(posedge clk_cpu) disable iff (rst)
    (mode == BOARD_DESKTOP && $stable(cpu_en) && !$past(rst)) |-> (cpu_gate_en == cpu_en));

  // R2: in desktop mode the PCI gates follow the register enables alone
  a_r2_desktop_pci_free: assert property (@(posedge clk_pci) disable iff (rst)
    (mode == BOARD_DESKTOP && $stable(pci_en) && !$past(rst)) |-> (pci_gate_en == pci_en));

endmodule

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;

  localparam int NCPU = 2;
  localparam int NPCI = 5;
  localparam int NV   = 8;

  // Vector layout: [17] strap, [16] cpu_stop_n, [15] pci_stop_n, [14:13] cpu_en,
  // [12:8] pci_en, [7] out_hiz, [6:5] expected CPU running, [4:0] expected PCI running
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 2'b11, 5'b11111, 1'b0, 2'b11, 5'b11111},
    {1'b0, 1'b0, 1'b1, 2'b11, 5'b11111, 1'b0, 2'b00, 5'b11111},
    {1'b0, 1'b1, 1'b0, 2'b11, 5'b11111, 1'b0, 2'b11, 5'b00000},
    {1'b0, 1'b0, 1'b0, 2'b11, 5'b11111, 1'b0, 2'b00, 5'b00000},
    {1'b0, 1'b1, 1'b1, 2'b01, 5'b10101, 1'b0, 2'b01, 5'b10101},
    {1'b1, 1'b0, 1'b0, 2'b11, 5'b11111, 1'b0, 2'b11, 5'b11111},
    {1'b1, 1'b1, 1'b0, 2'b10, 5'b01010, 1'b0, 2'b10, 5'b01010},
    {1'b1, 1'b1, 1'b1, 2'b11, 5'b11111, 1'b1, 2'b00, 5'b00000}
  };

  logic clk = 1'b0;
  logic pci = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic cs_n = 1'b1;
  logic ps_n = 1'b1;
  logic hiz = 1'b0;
  logic [NCPU-1:0] cen = '1;
  logic [NPCI-1:0] pen = '1;
  logic mobile;
  logic [NCPU-1:0] cpu_o;
  logic [NPCI-1:0] pci_o;
  logic pcif_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #8 pci = ~pci;
  end

  clkstop_ctrl #(.NUM_CPU(NCPU), .NUM_PCI(NPCI), .CPU_SYNC_STAGES(2)) uut (
    .clk_cpu    (clk),
    .clk_pci    (pci),
    .clk_pcif   (pci),
    .rst        (rst),
    .mode_strap (strap),
    .cpu_stop_n (cs_n),
    .pci_stop_n (ps_n),
    .cpu_en     (cen),
    .pci_en     (pen),
    .out_hiz    (hiz),
    .mobile_o   (mobile),
    .cpu_clk_o  (cpu_o),
    .pci_clk_o  (pci_o),
    .pcif_clk_o (pcif_o)
  );

  // Edge counters and pulse-width monitors
  int cpu_rise [NCPU];
  int pci_rise [NPCI];
  int pcif_rise = 0;
  int cpu_runts = 0;
  int pci_runts = 0;
  realtime cpu_t [NCPU];
  realtime pci_t [NPCI];
  logic [NCPU-1:0] cpu_prev = '0;
  logic [NPCI-1:0] pci_prev = '0;
  int cpu_snap [NCPU];
  int pci_snap [NPCI];
  int pcif_snap = 0;

  always @(cpu_o) begin
    for (int i = 0; i < NCPU; i++) begin
      if (cpu_prev[i] !== 1'b1 && cpu_o[i] === 1'b1) begin
        cpu_rise[i]++;
        cpu_t[i] = $realtime;
      end else if (cpu_prev[i] === 1'b1 && cpu_o[i] === 1'b0 && ($realtime - cpu_t[i]) < 1.9) begin
        cpu_runts++;
      end
    end
    cpu_prev = cpu_o;
  end

  always @(pci_o) begin
    for (int i = 0; i < NPCI; i++) begin
      if (pci_prev[i] !== 1'b1 && pci_o[i] === 1'b1) begin
        pci_rise[i]++;
        pci_t[i] = $realtime;
      end else if (pci_prev[i] === 1'b1 && pci_o[i] === 1'b0 && ($realtime - pci_t[i]) < 7.9) begin
        pci_runts++;
      end
    end
    pci_prev = pci_o;
  end

  always @(posedge pcif_o) begin
    if (pcif_o === 1'b1) pcif_rise++;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input string what, input int act,
                             input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", tag, what, act, lo, hi);
    end
  endtask

  task automatic snapshot();
    for (int i = 0; i < NCPU; i++) cpu_snap[i] = cpu_rise[i];
    for (int i = 0; i < NPCI; i++) pci_snap[i] = pci_rise[i];
    pcif_snap = pcif_rise;
  endtask

  function automatic string tag_of(input int v);
    case (v)
      0: return "R10";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R8";
      5: return "R2";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic do_reset(input logic s);
    @(negedge pci);
    rst = 1'b1; strap = s; cs_n = 1'b1; ps_n = 1'b1; cen = '1; pen = '1; hiz = 1'b0;
    repeat (3) @(posedge pci);
    #1 snapshot();
    repeat (3) @(posedge pci);
    #1;
    // R10: gated outputs LOW and silent while reset is held
    for (int i = 0; i < NCPU; i++) begin
      check("R10", "cpu edges in reset", cpu_rise[i] - cpu_snap[i], 0);
      check("R10", "cpu level in reset", (cpu_o[i] === 1'b0) ? 1 : 0, 1);
    end
    for (int i = 0; i < NPCI; i++)
      check("R10", "pci edges in reset", pci_rise[i] - pci_snap[i], 0);
    check("R5", "pcif edges in reset", pcif_rise - pcif_snap, 3);
    @(negedge pci);
    rst = 1'b0;
    repeat (2) @(posedge pci);
    #1 check("R1", "mobile flag", (mobile === 1'b1) ? 1 : 0, s ? 0 : 1);
  endtask

  logic [17:0] e;
  logic cur_strap;
  int n;

  initial begin
    cur_strap = 1'b0;
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      if (v == 0 || e[17] != cur_strap) begin
        do_reset(e[17]);
        cur_strap = e[17];
      end
      @(negedge pci);
      cs_n = e[16]; ps_n = e[15]; cen = e[14:13]; pen = e[12:8]; hiz = e[7];
      repeat (3) @(posedge pci);
      #1 snapshot();
      repeat (4) @(posedge pci);
      #1;
      for (int i = 0; i < NCPU; i++) begin
        if (e[7]) begin
          check(tag_of(v), "cpu output floating", (cpu_o[i] === 1'bz) ? 1 : 0, 1);
        end else begin
          check(tag_of(v), "cpu edges", cpu_rise[i] - cpu_snap[i], e[5+i] ? 16 : 0);
          if (!e[5+i]) check("R6", "cpu held low", (cpu_o[i] === 1'b0) ? 1 : 0, 1);
        end
      end
      for (int i = 0; i < NPCI; i++) begin
        if (e[7]) begin
          check(tag_of(v), "pci output floating", (pci_o[i] === 1'bz) ? 1 : 0, 1);
        end else begin
          check(tag_of(v), "pci edges", pci_rise[i] - pci_snap[i], e[i] ? 4 : 0);
          if (!e[i]) check("R6", "pci held low", (pci_o[i] === 1'b0) ? 1 : 0, 1);
        end
      end
      if (e[7]) check("R9", "pcif floating", (pcif_o === 1'bz) ? 1 : 0, 1);
      else      check("R5", "pcif edges", pcif_rise - pcif_snap, 4);
    end

    // Directed: mobile mode, strap moved after reset, then CPU latency
    do_reset(1'b0);
    @(negedge pci);
    strap = 1'b1;
    @(negedge pci);
    cs_n = 1'b0;
    @(posedge pci);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      #1;
      if (cpu_o[0] === 1'b1) n++;
      else break;
    end
    check_range("R3", "cpu pulses after stop sample", n, 2, 4);
    repeat (2) @(posedge pci);
    #1 check("R3", "cpu1 stopped", (cpu_o[1] === 1'b0) ? 1 : 0, 1);
    check("R1", "mobile kept after strap change", (mobile === 1'b1) ? 1 : 0, 1);
    @(negedge pci);
    cs_n = 1'b1;
    @(posedge pci);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      #1;
      if (cpu_o[0] === 1'b1) break;
      n++;
    end
    check_range("R3", "cpu edges skipped before restart", n, 2, 4);

    // Directed: PCI one-cycle latency in both directions
    @(negedge pci);
    ps_n = 1'b0;
    @(posedge pci);
    #1 check("R4", "pulse at stop sample edge", (pci_o[0] === 1'b1) ? 1 : 0, 1);
    @(posedge pci);
    #1 check("R4", "stopped one cycle later", (pci_o[0] === 1'b0) ? 1 : 0, 1);
    @(negedge pci);
    ps_n = 1'b1;
    @(posedge pci);
    #1 check("R4", "still low at start sample edge", (pci_o[0] === 1'b0) ? 1 : 0, 1);
    @(posedge pci);
    #1 check("R4", "running one cycle later", (pci_o[0] === 1'b1) ? 1 : 0, 1);

    // R7: no shortened pulse seen anywhere during the run
    check("R7", "cpu runt pulses", cpu_runts, 0);
    check("R7", "pci runt pulses", pci_runts, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule